// File: doc/BRIEF.md
# Multi-Bank Row State Merger

This block is the middle stage of a three-stage zero-suppression pipeline for a rolling-shutter pixel sensor. At every row strobe it captures the state lists that a set of parallel bank encoders produced for that row, together with each bank's state count and the row address from the row sequencer. It then merges those lists into a single bounded list for the row and writes it, one word per clock, to the frame memory stage that follows.

Banks are served in ascending bank index, and within a bank in the order of the encoder's slots. Each output state is tagged with its bank index. At most `MAX_STATES` states leave per row; any further states are dropped. A header word closes each non-empty row. It carries the row address, the number of states written and an overflow flag. The flag is raised when states were dropped or when the next row strobe cut the row short.

Top module: `row_state_merger`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with no strobe, `wr_valid` and `wr_header` are 0.
- R2: A row captured at a strobe edge emits its data words on consecutive edges starting at the next edge, one per cycle, with banks in ascending order and, within a bank, slots in ascending order (slot j of bank b is `bank_states[(b*STATES_PER_BANK+j)*8 +: 8]`).
- R3: A data word has `wr_header`=0 and holds bank index in bits [12:8], column in bits [7:2] and run length in bits [1:0]; the state input byte is {column[5:0], run[1:0]}.
- R4: No more than `MAX_STATES` data words are written per row; states beyond that number in merge order are discarded.
- R5: On the edge after a row's last data word, a header word is written with `wr_header`=1 and `wr_valid`=1: row address in bits [ROW_W-1:0], written count in the next `$clog2(MAX_STATES+1)` bits, and the overflow flag in the bit above. The overflow flag is 1 exactly when the row offered more than `MAX_STATES` states. No header is written for a row that offered no state.
- R6: A row strobe that arrives while a row still has unwritten accepted states closes that row: its header, with the count written so far and overflow set to 1, is emitted on the strobe edge, and the new row starts.
- R7: A bank count larger than `STATES_PER_BANK` is treated as `STATES_PER_BANK`.
- R8: `wr_header` is never 1 while `wr_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_strobe | input | 1 | Captures a new row and closes the current one |
| row_addr | input | ROW_W | Row address from the row sequencer |
| bank_states | input | NUM_BANKS*STATES_PER_BANK*8 | Encoded states of all banks, slot-major per bank |
| bank_counts | input | NUM_BANKS*$clog2(STATES_PER_BANK+1) | Valid state count per bank |
| wr_valid | output | 1 | Write strobe to the frame memory |
| wr_header | output | 1 | Marks the written word as a row header |
| wr_word | output | max(13, ROW_W+$clog2(MAX_STATES+1)+1) | Formatted data or header word |

## Verification
The assertions take for granted that states, counts and the row address are stable only at the strobe edge, since the block captures them there and ignores them afterwards. They also assume that a strobe is the only event that starts a row, so the bank-order and per-row word-count trackers restart on it. The bench drives all inputs one cycle around each strobe and then holds strobe low for a chosen gap. It sweeps every count combination, including counts above the slot number, on a small configuration. It also steps the gap between strobes across the window in which a row can be cut short.

// File: rtl/merger_pkg.sv
package merger_pkg;
   localparam int BANK_W  = 5;
   localparam int COL_W   = 6;
   localparam int RUN_W   = 2;
   localparam int STATE_W = COL_W + RUN_W;
   localparam int DATA_W  = BANK_W + STATE_W;
endpackage

// File: rtl/merge_prefix.sv
module merge_prefix #(
   parameter int NUM_BANKS       = 18,
   parameter int STATES_PER_BANK = 4,
   parameter int CNT_W           = 3,
   parameter int TOT_W           = 7
) (
   input  logic [NUM_BANKS*CNT_W-1:0] raw_counts,
   output logic [NUM_BANKS*CNT_W-1:0] clamped,
   output logic [NUM_BANKS*TOT_W-1:0] starts,
   output logic [TOT_W-1:0]           total
);
   localparam logic [CNT_W-1:0] CAP = CNT_W'(STATES_PER_BANK);

   logic [TOT_W-1:0] acc;
   logic [CNT_W-1:0] c;

   always_comb begin
      acc     = '0;
      c       = '0;
      clamped = '0;
      starts  = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         c = raw_counts[b*CNT_W +: CNT_W];
         if (c > CAP) c = CAP;
         clamped[b*CNT_W +: CNT_W] = c;
         starts[b*TOT_W +: TOT_W]  = acc;
         acc = acc + TOT_W'(c);
      end
      total = acc;
   end
endmodule

// File: rtl/merge_pick.sv
module merge_pick
   import merger_pkg::*;
#(
   parameter int NUM_BANKS       = 18,
   parameter int STATES_PER_BANK = 4,
   parameter int CNT_W           = 3,
   parameter int TOT_W           = 7
) (
   input  logic [TOT_W-1:0]                           idx,
   input  logic [NUM_BANKS*CNT_W-1:0]                 counts,
   input  logic [NUM_BANKS*TOT_W-1:0]                 starts,
   input  logic [NUM_BANKS*STATES_PER_BANK*STATE_W-1:0] states,
   output logic [BANK_W-1:0]                          bank_sel,
   output logic [STATE_W-1:0]                         state_sel
);
   logic [TOT_W-1:0] lo;
   logic [TOT_W-1:0] hi;

   always_comb begin
      bank_sel  = '0;
      state_sel = '0;
      lo        = '0;
      hi        = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         lo = starts[b*TOT_W +: TOT_W];
         hi = lo + TOT_W'(counts[b*CNT_W +: CNT_W]);
         if (idx >= lo && idx < hi) begin
            bank_sel = BANK_W'(b);
            for (int j = 0; j < STATES_PER_BANK; j++) begin
               if (idx - lo == TOT_W'(j))
                  state_sel = states[(b*STATES_PER_BANK + j)*STATE_W +: STATE_W];
            end
         end
      end
   end
endmodule

// File: rtl/row_state_merger.sv
module row_state_merger
   import merger_pkg::*;
#(
   parameter int NUM_BANKS       = 18,
   parameter int STATES_PER_BANK = 4,
   parameter int MAX_STATES      = 9,
   parameter int ROW_W           = 10,
   localparam int CNT_W  = $clog2(STATES_PER_BANK + 1),
   localparam int MCNT_W = $clog2(MAX_STATES + 1),
   localparam int HDR_W  = ROW_W + MCNT_W + 1,
   localparam int WORD_W = (HDR_W > DATA_W) ? HDR_W : DATA_W
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       row_strobe,
   input  logic [ROW_W-1:0]                           row_addr,
   input  logic [NUM_BANKS*STATES_PER_BANK*STATE_W-1:0] bank_states,
   input  logic [NUM_BANKS*CNT_W-1:0]                 bank_counts,
   output logic                                       wr_valid,
   output logic                                       wr_header,
   output logic [WORD_W-1:0]                          wr_word
);
   localparam int TOT_W = $clog2(NUM_BANKS*STATES_PER_BANK + 1);
   localparam logic [TOT_W-1:0] LIMIT = TOT_W'(MAX_STATES);

   generate
      if (NUM_BANKS < 1 || NUM_BANKS > (1 << BANK_W)) begin : g_bad_banks
         $error("NUM_BANKS must fit the bank field");
      end
      if (MAX_STATES < 1 || MAX_STATES > NUM_BANKS*STATES_PER_BANK) begin : g_bad_limit
         $error("MAX_STATES out of range");
      end
      if (STATES_PER_BANK < 1 || ROW_W < 1) begin : g_bad_sizes
         $error("STATES_PER_BANK and ROW_W must be positive");
      end
   endgenerate

   logic [NUM_BANKS*STATES_PER_BANK*STATE_W-1:0] cap_states;
   logic [NUM_BANKS*CNT_W-1:0]                   cap_counts;
   logic [ROW_W-1:0]                             row_q;
   logic                                         active;
   logic [TOT_W-1:0]                             k;

   logic [NUM_BANKS*CNT_W-1:0] clamped;
   logic [NUM_BANKS*TOT_W-1:0] starts;
   logic [TOT_W-1:0]           total;
   logic [TOT_W-1:0]           accepted;
   logic [BANK_W-1:0]          bank_sel;
   logic [STATE_W-1:0]         state_sel;

   merge_prefix #(
      .NUM_BANKS(NUM_BANKS), .STATES_PER_BANK(STATES_PER_BANK),
      .CNT_W(CNT_W), .TOT_W(TOT_W)
   ) u_prefix (
      .raw_counts(cap_counts), .clamped(clamped), .starts(starts), .total(total)
   );

   merge_pick #(
      .NUM_BANKS(NUM_BANKS), .STATES_PER_BANK(STATES_PER_BANK),
      .CNT_W(CNT_W), .TOT_W(TOT_W)
   ) u_pick (
      .idx(k), .counts(clamped), .starts(starts), .states(cap_states),
      .bank_sel(bank_sel), .state_sel(state_sel)
   );

   assign accepted = (total > LIMIT) ? LIMIT : total;

   function automatic logic [WORD_W-1:0] make_header(input logic ovf,
                                                     input logic [TOT_W-1:0] n,
                                                     input logic [ROW_W-1:0] r);
      return WORD_W'({ovf, n[MCNT_W-1:0], r});
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active     <= 1'b0;
         k          <= '0;
         row_q      <= '0;
         cap_states <= '0;
         cap_counts <= '0;
         wr_valid   <= 1'b0;
         wr_header  <= 1'b0;
         wr_word    <= '0;
      end else begin
         wr_valid  <= 1'b0;
         wr_header <= 1'b0;
         if (row_strobe) begin
            if (active && total != '0) begin
               wr_valid  <= 1'b1;
               wr_header <= 1'b1;
               wr_word   <= make_header((k < accepted) || (total > LIMIT), k, row_q);
            end
            cap_states <= bank_states;
            cap_counts <= bank_counts;
            row_q      <= row_addr;
            active     <= 1'b1;
            k          <= '0;
         end else if (active) begin
            if (k < accepted) begin
               wr_valid <= 1'b1;
               wr_word  <= WORD_W'({bank_sel, state_sel});
               k        <= k + 1'b1;
            end else begin
               if (total != '0) begin
                  wr_valid  <= 1'b1;
                  wr_header <= 1'b1;
                  wr_word   <= make_header(total > LIMIT, k, row_q);
               end
               active <= 1'b0;
            end
         end
      end
   end

   // trackers for the output-side checks
   logic [TOT_W-1:0]  seen_words;
   logic [BANK_W-1:0] last_bank;

   always_ff @(posedge clk) begin
      if (!rst_n || row_strobe) begin
         seen_words <= '0;
         last_bank  <= '0;
      end else if (wr_valid && !wr_header) begin
         seen_words <= seen_words + 1'b1;
         last_bank  <= wr_word[DATA_W-1 -: BANK_W];
      end
   end

   assert_marker_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_header |-> wr_valid);

   assert_word_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_header) |-> (seen_words < LIMIT));

   assert_header_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_header) |-> (wr_word[ROW_W +: MCNT_W] <= MCNT_W'(MAX_STATES)));

   assert_empty_close_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_header && wr_word[ROW_W +: MCNT_W] == '0) |-> wr_word[ROW_W + MCNT_W]);

   assert_bank_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_header) |-> (wr_word[DATA_W-1 -: BANK_W] >= last_bank));

   assert_bank_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_header) |-> (32'(wr_word[DATA_W-1 -: BANK_W]) < NUM_BANKS));
endmodule

// File: tb/sim_row_state_merger.sv
module sim_row_state_merger;
   localparam int CLK_PERIOD = 10;
   localparam int NB = 4;
   localparam int NS = 2;
   localparam int MS = 3;
   localparam int RW = 6;
   localparam int CW = 2;
   localparam int WW = 13;
   localparam int LOGN = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic row_strobe = 1'b0;
   logic [RW-1:0] row_addr = '0;
   logic [NB*NS*8-1:0] bank_states = '0;
   logic [NB*CW-1:0] bank_counts = '0;
   logic wr_valid, wr_header;
   logic [WW-1:0] wr_word;

   row_state_merger #(.NUM_BANKS(NB), .STATES_PER_BANK(NS), .MAX_STATES(MS), .ROW_W(RW)) u0 (
      .clk(clk), .rst_n(rst_n), .row_strobe(row_strobe), .row_addr(row_addr),
      .bank_states(bank_states), .bank_counts(bank_counts),
      .wr_valid(wr_valid), .wr_header(wr_header), .wr_word(wr_word));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;
   bit logging = 0;

   logic [WW:0] got [LOGN];
   logic [WW:0] expw [LOGN];
   int got_n = 0;
   int exp_n = 0;
   int cnt [NB];

   always @(negedge clk) begin
      if (logging && wr_valid && got_n < LOGN) begin
         got[got_n] = {wr_header, wr_word};
         got_n++;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 100000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [7:0] state_of(int b, int j, int row);
      logic [5:0] col = 6'((b*11 + j*5 + row) & 63);
      logic [1:0] run = 2'((b + j + row) & 3);
      return {col, run};
   endfunction

   task automatic check(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
      end
   endtask

   // R2 R3 R4 R5 R6 R7 model: expected words for one row given the gap to the next strobe
   task automatic add_expected(int row, int gap);
      logic [WW:0] lst [NB*NS];
      int total = 0;
      int acc, written, c;
      bit ovf;
      for (int b = 0; b < NB; b++) begin
         c = (cnt[b] > NS) ? NS : cnt[b];
         for (int j = 0; j < c; j++) begin
            lst[total] = {1'b0, 13'((b << 8) | int'(state_of(b, j, row)))};
            total++;
         end
      end
      if (total == 0) return;
      acc = (total > MS) ? MS : total;
      written = (gap - 1 < acc) ? gap - 1 : acc;
      ovf = (written < acc) || (total > MS);
      for (int i = 0; i < written; i++) begin
         expw[exp_n] = lst[i];
         exp_n++;
      end
      expw[exp_n] = {1'b1, 13'((int'(ovf) << 8) | (written << 6) | row)};
      exp_n++;
   endtask

   task automatic issue_row(int row, int gap);
      row_addr   = RW'(row);
      row_strobe = 1'b1;
      for (int b = 0; b < NB; b++) begin
         bank_counts[b*CW +: CW] = CW'(cnt[b]);
         for (int j = 0; j < NS; j++)
            bank_states[(b*NS + j)*8 +: 8] = state_of(b, j, row);
      end
      add_expected(row, gap);
      @(negedge clk);
      row_strobe  = 1'b0;
      bank_states = '1;
      bank_counts = '1;
      row_addr    = '1;
      repeat (gap - 1) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(wr_valid == 1'b0 && wr_header == 1'b0, "R1", {wr_valid, wr_header}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(wr_valid == 1'b0 && wr_header == 1'b0, "R1", {wr_valid, wr_header}, 0);
      logging = 1;

      // exhaustive sweep of counts 0..3 per bank (3 exceeds NS: R7)
      for (int v = 0; v < 256; v++) begin
         for (int b = 0; b < NB; b++) cnt[b] = (v >> (2*b)) & 3;
         issue_row(v & 63, MS + 2);
      end

      // early strobe: full row cut short at each gap (R6)
      for (int g = 1; g <= MS + 2; g++) begin
         for (int b = 0; b < NB; b++) cnt[b] = 2;
         issue_row(40 + g, g);
      end
      // empty row followed at once by another (R5: no header)
      for (int b = 0; b < NB; b++) cnt[b] = 0;
      issue_row(7, 1);
      cnt[0] = 0; cnt[1] = 1; cnt[2] = 0; cnt[3] = 3;
      issue_row(9, 2);
      cnt[0] = 1; cnt[1] = 0; cnt[2] = 2; cnt[3] = 0;
      issue_row(11, 20);

      logging = 0;
      check(got_n == exp_n, "R2", got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++) begin
         if (expw[i][WW])
            check(got[i] == expw[i], (expw[i][8] ? "R6" : "R5"), int'(got[i]), int'(expw[i]));
         else
            check(got[i] == expw[i], "R3", int'(got[i]), int'(expw[i]));
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule